// File: doc/BRIEF.md
# Auxiliary UART Register Front End

This block is the bus-facing half of a reduced auxiliary UART. Software reaches it through a 32-bit word port. A byte stream from a receive deserializer is buffered in a small circular FIFO that software drains through the data register. Bytes that software writes to the data register leave at once on a transmit byte output with a one-cycle strobe. The transmit side is modelled as always drained, so it never applies back-pressure.

A single level interrupt combines a receive source and a transmit source under a two-bit enable. Most read values are fixed patterns with FIFO occupancy and interrupt state merged in. Registers for framing, baud rate, line and modem control, and scratch storage decode, but they hold nothing: writes to them are dropped and reads return zero.

Top module: `muart_regs`

## Requirements
- R1: After synchronous reset the FIFO is empty with its read pointer at slot 0, the enable bits are 0, `irq`, `tx_valid` and `bus_rdata` are 0, and `rx_ready` is 1.
- R2: A write to offset 0x44 stores write-data bits 1:0 (bit 0 is the receive enable, bit 1 the transmit enable) and ignores the rest. A read of 0x44 returns 0xC0 ORed with the stored bits.
- R3: `irq` is 1 exactly when bit 1 is enabled, or when bit 0 is enabled and the FIFO is non-empty. A read of offset 0x00 returns 1 when `irq` is 1 and 0 otherwise.
- R4: A read of offset 0x48 returns 0xC0, plus 0x4 if the FIFO holds data or 0x2 if it is empty, plus 0x1 if `irq` is 0. The receive code takes priority over the transmit code.
- R5: A write to offset 0x48 with write-data bit 1 set empties the FIFO. `rx_ready` is 0 during that write cycle, so no byte is lost. With bit 1 clear the write has no effect.
- R6: A byte is taken into the FIFO on a clock edge where `rx_valid` and `rx_ready` are both 1. The FIFO holds DEPTH (8) bytes, and `rx_ready` is 0 while it is full. A push and a pop in the same cycle leave the fill level unchanged.
- R7: A read of offset 0x40 on a non-empty FIFO returns the oldest byte, advances the read pointer with wraparound and lowers the fill level by one. Bytes come out in arrival order.
- R8: A read of offset 0x40 on an empty FIFO returns the byte stored in the slot at the read pointer and changes no state.
- R9: A write to offset 0x40 raises `tx_valid` for exactly one cycle, on the cycle after the write, with `tx_data` equal to write-data bits 7:0. `tx_valid` is 0 at all other times.
- R10: A read of offset 0x54 returns 0x60, with bit 0 set when the FIFO is non-empty.
- R11: A read of offset 0x64 returns 0x30E. When the FIFO is non-empty, bit 0 is also set and the fill level sits in bits 19:16.
- R12: Offset 0x04 reads 1 and offset 0x60 reads 3. Writes to either have no effect.
- R13: Offsets 0x4C, 0x50, 0x58, 0x5C and 0x68, every unlisted byte address and every address that is not word aligned read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered on the edge that samples `bus_rd` |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | FIFO can accept a byte this cycle |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
A register read takes effect on the edge that samples `bus_rd`. Its value, and any pop it causes, are visible just after that edge. The transmit strobe appears on the cycle after the write edge and clears one cycle later. `irq` and `rx_ready` are gates on registered state, so they follow each state update right after the same edge. `rx_ready` also drops combinationally while a flush write is being presented. The bench drives its inputs on the falling edge, samples 1 ns after the rising edge that performs the operation, and checks `rx_ready` on the falling edge where the offer is made, before the edge that decides it.

// File: rtl/muart_pkg.sv
package muart_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENABLES = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_IID     = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_LINE    = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h64;

  localparam logic [31:0] IEN_FIXED  = 32'h0000_00C0;
  localparam logic [31:0] IID_FIXED  = 32'h0000_00C0;
  localparam logic [31:0] LINE_FIXED = 32'h0000_0060;
  localparam logic [31:0] STAT_FIXED = 32'h0000_030E;
  localparam logic [31:0] ENA_VALUE  = 32'h0000_0001;
  localparam logic [31:0] CTRL_VALUE = 32'h0000_0003;
  localparam int          STAT_FILL_LSB = 16;
endpackage

// File: rtl/muart_rx_fifo.sv
module muart_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  fill,
  output logic              full
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic              do_pop;

  // DEPTH is a power of two, so the sum wraps on its own
  assign wr_ptr = rd_ptr + fill[PTR_W-1:0];
  assign do_pop = pop && (fill != '0);
  assign full   = (fill == CNT_W'(DEPTH));

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) begin
      store[wr_ptr] <= push_data;
    end
  end

  assign head_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      fill <= '0;
    end else begin
      if (do_pop) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
      fill <= fill + CNT_W'(push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/muart_irq_ctrl.sv
module muart_irq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       ien_we,
  input  logic [1:0] ien_wdata,
  input  logic       rx_nonempty,
  output logic [1:0] ien,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= 2'b00;
    end else if (ien_we) begin
      ien <= ien_wdata;
    end
  end

  // transmit side is always drained, so its source is the enable itself
  assign irq = (ien[0] && rx_nonempty) || ien[1];
endmodule

// File: rtl/muart_rd_mux.sv
module muart_rd_mux
  import muart_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ien,
  input  logic              irq,
  input  logic [CNT_W-1:0]  fill,
  input  logic [DATA_W-1:0] head_data,
  output logic [31:0]       rvalue
);
  logic has_data;
  assign has_data = (fill != '0);

  always_comb begin
    rvalue = '0;
    unique case (addr)
      OFS_SUMMARY: rvalue = {31'b0, irq};
      OFS_ENABLES: rvalue = ENA_VALUE;
      OFS_DATA:    rvalue = 32'(head_data);
      OFS_IEN:     rvalue = IEN_FIXED | {30'b0, ien};
      OFS_IID:     rvalue = IID_FIXED | (has_data ? 32'h4 : 32'h2) | {31'b0, !irq};
      OFS_LINE:    rvalue = LINE_FIXED | {31'b0, has_data};
      OFS_CTRL:    rvalue = CTRL_VALUE;
      OFS_STAT:    rvalue = STAT_FIXED | {31'b0, has_data} | (32'(fill) << STAT_FILL_LSB);
      default:     rvalue = '0;
    endcase
  end
endmodule

// File: rtl/muart_regs.sv
module muart_regs
  import muart_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);
  logic              ien_we;
  logic              flush;
  logic              pop;
  logic              push;
  logic              full;
  logic [CNT_W-1:0]  fill;
  logic [DATA_W-1:0] head_data;
  logic [1:0]        ien;
  logic [31:0]       rvalue;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:DATA_W];

  assign ien_we   = bus_wr && (bus_addr == OFS_IEN);
  assign flush    = bus_wr && (bus_addr == OFS_IID) && bus_wdata[1];
  assign pop      = bus_rd && (bus_addr == OFS_DATA);
  assign rx_ready = !full && !flush;
  assign push     = rx_valid && rx_ready;

  muart_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (rx_data),
    .pop       (pop),
    .flush     (flush),
    .head_data (head_data),
    .fill      (fill),
    .full      (full)
  );

  muart_irq_ctrl irq_i (
    .clk         (clk),
    .rst         (rst),
    .ien_we      (ien_we),
    .ien_wdata   (bus_wdata[1:0]),
    .rx_nonempty (fill != '0),
    .ien         (ien),
    .irq         (irq)
  );

  muart_rd_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) mux_i (
    .addr      (bus_addr),
    .ien       (ien),
    .irq       (irq),
    .fill      (fill),
    .head_data (head_data),
    .rvalue    (rvalue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rvalue;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= bus_wr && (bus_addr == OFS_DATA);
      if (bus_wr && (bus_addr == OFS_DATA)) begin
        tx_data <= bus_wdata[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/muart_regs_chk.sv
module muart_regs_chk
  import muart_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              irq,
  input logic [CNT_W-1:0]  fill
);
  logic data_wr;
  logic flush_wr;
  assign data_wr  = bus_wr && (bus_addr == OFS_DATA);
  assign flush_wr = bus_wr && (bus_addr == OFS_IID) && bus_wdata[1];

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (tx_valid && tx_data == $past(bus_wdata))); // R9
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> !tx_valid); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (fill == CNT_W'(DEPTH)) |-> !rx_ready); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_wr |=> (fill == '0)); // R5
  AST_TX_IRQ: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_IEN && bus_wdata[1]) |=> irq); // R3
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && !(rx_valid && rx_ready)) |=> (fill == '0)); // R8
endmodule

bind muart_regs muart_regs_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata[DATA_W-1:0]),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .irq       (irq),
  .fill      (fill)
);

// File: tb/muart_regs_tb.sv
`timescale 1ns/1ps
module muart_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  always #2.5 clk = ~clk;

  muart_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_mem [8];
  int m_rptr = 0;
  int m_cnt = 0;
  logic [1:0] m_ien = 2'b00;

  function automatic logic m_irq();
    return (m_ien[0] && m_cnt != 0) || m_ien[1];
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_irq()};
      8'h04: return 32'h1;
      8'h44: return 32'hC0 | {30'b0, m_ien};
      8'h48: return 32'hC0 | ((m_cnt != 0) ? 32'h4 : 32'h2) | {31'b0, !m_irq()};
      8'h54: return 32'h60 | ((m_cnt != 0) ? 32'h1 : 32'h0);
      8'h60: return 32'h3;
      8'h64: return 32'h30E | ((m_cnt != 0) ? 32'h1 : 32'h0) | (32'(m_cnt) << 16);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    if (a == 8'h44) m_ien = d[1:0];
    if (a == 8'h48 && d[1]) m_cnt = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #0.5;
    chk("R6 rx_ready", {31'b0, rx_ready}, {31'b0, m_cnt < 8});
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (m_cnt < 8) begin
      m_mem[(m_rptr + m_cnt) % 8] = b;
      m_cnt++;
    end
  endtask

  task automatic read_data(input string req);
    logic [31:0] v;
    logic [31:0] e;
    e = 32'(m_mem[m_rptr]);
    bus_read(8'h40, v);
    if (m_cnt > 0) begin
      m_rptr = (m_rptr + 1) % 8;
      m_cnt--;
    end
    chk(req, v, e);
  endtask

  task automatic sweep(input string req);
    logic [31:0] v;
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h40) begin
        bus_read(8'(a), v);
        chk(req, v, exp_read(8'(a)));
      end
    end
    chk("R3 irq pin", {31'b0, irq}, {31'b0, m_irq()});
  endtask

  task automatic push_pop(input logic [7:0] b);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = 8'h40; bus_rd = 1'b1; rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    bus_rd = 1'b0; rx_valid = 1'b0;
    e = 32'(m_mem[m_rptr]);
    m_mem[(m_rptr + m_cnt) % 8] = b;
    m_rptr = (m_rptr + 1) % 8;
    chk("R6 push with pop data", bus_rdata, e);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    bus_read(8'h44, v); chk("R1 ien", v, 32'hC0);
    bus_read(8'h64, v); chk("R1 status", v, 32'h30E);

    // fill sweep over every level and every enable setting: R2 R3 R4 R10 R11 R12 R13
    for (int k = 0; k <= 8; k++) begin
      for (int e = 0; e < 4; e++) begin
        bus_write(8'h44, 32'hFFFF_FFFC | 32'(e));
        sweep("R2/R3/R4/R10/R11/R12/R13 level sweep");
      end
      if (k < 8) push(8'(k * 17 + 3));
    end
    // R6 push while full is refused
    push(8'hEE);
    bus_read(8'h64, v); chk("R6 full count", v, 32'h0008_030F);

    // R7 drain in order
    for (int k = 0; k < 8; k++) read_data("R7 fifo order");
    // R8 empty reads return stale slot, no change
    read_data("R8 empty read");
    read_data("R8 empty read again");
    bus_read(8'h64, v); chk("R8 still empty", v, 32'h30E);

    // R7 wraparound traffic
    for (int it = 0; it < 20; it++) begin
      push(8'(it * 7 + 1)); push(8'(it * 7 + 2)); push(8'(it * 7 + 3));
      read_data("R7 wrap pop"); read_data("R7 wrap pop");
      if (m_cnt >= 6) begin
        read_data("R7 wrap pop"); read_data("R7 wrap pop");
      end
    end
    while (m_cnt > 0) read_data("R7 wrap drain");

    // R6 push and pop together
    push(8'h5A); push(8'hA5);
    for (int k = 0; k < 5; k++) push_pop(8'(8'h30 + k));
    bus_read(8'h64, v); chk("R6 level kept", v, exp_read(8'h64));
    while (m_cnt > 0) read_data("R6 drain after push/pop");

    // R5 flush
    push(8'h11); push(8'h22); push(8'h33);
    bus_write(8'h48, 32'hFFFF_FFFD);
    bus_read(8'h64, v); chk("R5 bit1 clear keeps fifo", v, exp_read(8'h64));
    @(negedge clk);
    bus_addr = 8'h48; bus_wdata = 32'h2; bus_wr = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    #0.5;
    chk("R5 ready low in flush", {31'b0, rx_ready}, 32'h0);
    @(posedge clk); #1;
    bus_wr = 1'b0; rx_valid = 1'b0; m_cnt = 0;
    bus_read(8'h64, v); chk("R5 flushed", v, 32'h30E);
    bus_write(8'h44, 32'h1);
    chk("R5 no rx irq after flush", {31'b0, irq}, 32'h0);

    // R9 transmit strobe
    begin
      logic [31:0] tv [4];
      tv[0] = 32'h1A5; tv[1] = 32'hFF; tv[2] = 32'h0; tv[3] = 32'h1234_5680;
      for (int k = 0; k < 4; k++) begin
        bus_write(8'h40, tv[k]);
        chk("R9 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R9 tx_data", {24'b0, tx_data}, {24'b0, tv[k][7:0]});
        @(posedge clk); #1;
        chk("R9 strobe one cycle", {31'b0, tx_valid}, 32'h0);
      end
    end

    // R12 R13 writes to fixed and unmapped offsets have no effect
    push(8'h9C); push(8'hC9);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h40 && a != 8'h44 && a != 8'h48) begin
        bus_write(8'(a), 32'hFFFF_FFFF);
        chk("R13 no tx on other write", {31'b0, tx_valid}, 32'h0);
      end
    end
    sweep("R12/R13 after stray writes");
    read_data("R13 fifo kept"); read_data("R13 fifo kept");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule